// File: doc/BRIEF.md
# Two-Wire Slave Front End for a Byte-Wide Zero-Wait Memory

This block lets a two-wire (I2C) bus master read and write a 2048-byte memory that has no write delay. The system clock oversamples SCL and SDA through a short synchronizer. Start and Stop are found from SDA edges while SCL is high. Serial bytes are shifted MSB first and are turned into single-cycle strobes on a synchronous RAM port. The only thing the block drives onto the bus is an open-drain pull-low enable for SDA.

A transaction opens with a control byte. Its upper four bits name the device type, its next three bits pick one of eight 256-byte pages, and its lowest bit gives the direction. A write then takes a low address byte followed by any number of data bytes. Each data byte is stored before it is acknowledged, and the 11-bit pointer advances after every byte. A read takes no address byte. It continues from the pointer left by the previous access, fetching ahead so that each byte is ready when the master clocks it out. A write-protect input makes the block refuse data bytes.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the block releases SDA (`sda_pull_o` = 0), and the write strobe `mem_we_o` and the read strobe `mem_re_o` are both low.
- R2: The block acknowledges the control byte when bits 7:4 equal 4'b1010. Otherwise it answers NACK and ignores the bus, not pulling SDA for any later byte, until the next Start.
- R3: In a write (control bit 0 = 0), the byte after the control byte is acknowledged and becomes pointer bits 7:0, with control bits 3:1 as pointer bits 10:8. Each following data byte is written at the pointer after its eighth bit, before its ACK is driven.
- R4: The pointer advances by one after each stored or fetched byte and wraps from 0x7FF to 0x000.
- R5: While `wp_i` is high, a data byte of a write gets NACK, is not stored, and leaves the pointer unchanged. The control and low-address bytes are still acknowledged.
- R6: In a read (control bit 0 = 1), the page comes from control bits 3:1 and the low bits come from the retained pointer. Bytes go out MSB first. A master ACK continues with the next byte, and a master NACK ends the read with SDA released.
- R7: A Start or Stop that arrives before the eighth bit of a data byte aborts the write and leaves memory unchanged. A Start always re-arms the block for a new control byte.
- R8: The block changes its SDA drive only while SCL is low.
- R9: The write and read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level as seen at the pad |
| sda_i | input | 1 | Bus data level as seen at the pad |
| wp_i | input | 1 | Write protect; high refuses data bytes |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| mem_addr_o | output | 11 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_re_o | output | 1 | One-cycle read strobe; data is expected on `mem_rdata_i` the following cycle |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
The hardest states to reach from the ports are the aborted data bytes and the point where the pointer wraps. A Start or Stop has to land after some of a byte's bits but before its eighth bit. The wrap needs page 7 with a low byte of 0xFF, followed by a read that continues across the boundary. The bench's bit-level master can stop a byte after any number of bits and can issue a repeated Start. It reads memory back only through the bus, so both the abort and the wrap show up as byte values in the scoreboard. Write protect is checked the same way. The refused byte must read back as the old value, and a read from the retained pointer shows whether the pointer moved.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    // Position of the engine within a byte transfer
    typedef enum logic [2:0] {
        ST_IDLE,     // ignoring the bus until a Start
        ST_RX,       // shifting in a byte from the master
        ST_ACKWAIT,  // byte complete, waiting for SCL low to drive the answer
        ST_ACK,      // ninth clock; the next fall begins a new byte
        ST_TX,       // shifting a byte out to the master
        ST_MACK      // SDA released, sampling the master's answer
    } phase_e;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        K_DEV,
        K_WORD,
        K_DATA
    } kind_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl;
        logic [STAGES-1:0] sda;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl   = {q.scl[STAGES-2:0], scl_i};
        d.sda   = {q.sda[STAGES-2:0], sda_i};
        d.scl_p = q.scl[STAGES-1];
        d.sda_p = q.sda[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;   // an idle bus has both lines high
        else        q <= d;
    end

    assign scl_o   = q.scl[STAGES-1];
    assign sda_o   = q.sda[STAGES-1];
    assign rise_o  = scl_o & ~q.scl_p;
    assign fall_o  = ~scl_o & q.scl_p;
    assign start_o = scl_o & q.scl_p & q.sda_p & ~sda_o;
    assign stop_o  = scl_o & q.scl_p & ~q.sda_p & sda_o;

endmodule

// File: rtl/twi_byte_fsm.sv
module twi_byte_fsm
    import twi_mem_pkg::*;
#(
    parameter int         ADDR_W = 11,
    parameter int         PAGE_W = 3,
    parameter logic [3:0] DEV_ID = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              wp_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o
);

    localparam int LOW_W = ADDR_W - PAGE_W;

    typedef struct packed {
        phase_e            st;
        kind_e             kind;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              rw;
        logic              ack;
        logic              pull;
        logic              we;
        logic              re;
        logic              load;
        logic [ADDR_W-1:0] maddr;
        logic [7:0]        wdata;
    } fsm_t;

    fsm_t       q, d;
    logic [7:0] byte_v;

    assign byte_v = {q.sh[6:0], sda_i};

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.re   = 1'b0;
        d.load = q.re;                 // RAM answers one cycle after the strobe
        if (q.load) d.sh = mem_rdata_i;

        if (start_i) begin
            d.st   = ST_RX;
            d.kind = K_DEV;
            d.cnt  = 4'd0;
            d.pull = 1'b0;
        end else if (stop_i) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_RX: if (rise_i) begin
                    d.sh  = byte_v;
                    d.cnt = q.cnt + 4'd1;
                    if (q.cnt == 4'd7) begin
                        d.st  = ST_ACKWAIT;
                        d.ack = 1'b0;
                        case (q.kind)
                            K_DEV: if (byte_v[7:4] == DEV_ID) begin
                                d.ptr[ADDR_W-1:LOW_W] = byte_v[PAGE_W:1];
                                d.rw   = byte_v[0];
                                d.ack  = 1'b1;
                                d.kind = K_WORD;
                            end
                            K_WORD: begin
                                d.ptr[LOW_W-1:0] = byte_v[LOW_W-1:0];
                                d.ack  = 1'b1;
                                d.kind = K_DATA;
                            end
                            default: if (!wp_i) begin
                                d.we    = 1'b1;
                                d.maddr = q.ptr;
                                d.wdata = byte_v;
                                d.ptr   = q.ptr + ADDR_W'(1);
                                d.ack   = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACKWAIT: if (fall_i) begin
                    if (q.ack) begin
                        d.pull = 1'b1;
                        d.st   = ST_ACK;
                        if (q.rw) begin        // fetch the first read byte now
                            d.re    = 1'b1;
                            d.maddr = q.ptr;
                            d.ptr   = q.ptr + ADDR_W'(1);
                        end
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                ST_ACK: if (fall_i) begin
                    if (q.rw) begin
                        d.pull = ~q.sh[7];
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.cnt  = 4'd1;
                        d.st   = ST_TX;
                    end else begin
                        d.pull = 1'b0;
                        d.cnt  = 4'd0;
                        d.st   = ST_RX;
                    end
                end
                ST_TX: if (fall_i) begin
                    if (q.cnt == 4'd8) begin
                        d.pull = 1'b0;
                        d.st   = ST_MACK;
                    end else begin
                        d.pull = ~q.sh[7];
                        d.sh   = {q.sh[6:0], 1'b0};
                        d.cnt  = q.cnt + 4'd1;
                    end
                end
                ST_MACK: if (rise_i) begin
                    if (!sda_i) begin
                        d.re    = 1'b1;
                        d.maddr = q.ptr;
                        d.ptr   = q.ptr + ADDR_W'(1);
                        d.st    = ST_ACK;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_pull_o  = q.pull;
    assign mem_addr_o  = q.maddr;
    assign mem_wdata_o = q.wdata;
    assign mem_we_o    = q.we;
    assign mem_re_o    = q.re;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && !start_i) |=> (q.st == ST_IDLE));

    // R5
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !$past(wp_i));

    // R3
    we_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (q.st == ST_ACKWAIT && q.ack));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int         ADDR_W      = 11,
    parameter int         PAGE_W      = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_ID      = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wp_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    input  logic [7:0]        mem_rdata_i
);

    logic scl_s, sda_s, rise, fall, start, stop;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_o   (scl_s),
        .sda_o   (sda_s),
        .rise_o  (rise),
        .fall_o  (fall),
        .start_o (start),
        .stop_o  (stop)
    );

    twi_byte_fsm #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .DEV_ID (DEV_ID)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_i       (sda_s),
        .rise_i      (rise),
        .fall_i      (fall),
        .start_i     (start),
        .stop_i      (stop),
        .wp_i        (wp_i),
        .mem_rdata_i (mem_rdata_i),
        .sda_pull_o  (sda_pull_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o)
    );

    // R8
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_s);

endmodule

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;

    localparam int Q = 10;   // clock cycles per quarter of an SCL period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        wp = 1'b0;
    logic        sda_pull;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [7:0]  mem_rdata = 8'h00;
    logic        sda_bus;

    int total = 0;
    int bad = 0;
    int r8_viol = 0;
    int r9_viol = 0;
    logic prev_pull = 1'b0;

    logic [7:0] ram [0:2047];
    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];

    always #10 clk = ~clk;   // 50 MHz

    assign sda_bus = m_sda & ~sda_pull;

    twi_mem_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_bus),
        .wp_i        (wp),
        .sda_pull_o  (sda_pull),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_we_o    (mem_we),
        .mem_re_o    (mem_re),
        .mem_rdata_i (mem_rdata)
    );

    initial for (int i = 0; i < 2048; i++) ram[i] = 8'h00;

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // port-level observers for R8 and R9
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_scl && sda_pull != prev_pull) r8_viol++;
            if (mem_we && mem_re) r9_viol++;
        end
        prev_pull = sda_pull;
    end

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0) begin
            logic [7:0] a, e;
            a = act_q.pop_front();
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(a == e, "R6 read byte", a, e);
            end else begin
                chk(1'b0, "R6 unexpected read byte", a, 0);
            end
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    // returns the ninth-bit level: 0 = ACK, 1 = NACK
    task automatic send_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(nack);
    endtask

    task automatic recv_byte(input logic give_ack);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        act_q.push_back(v);
        send_bit(~give_ack);
    endtask

    task automatic expect_byte(input logic [7:0] v);
        exp_q.push_back(v);
    endtask

    task automatic put(input logic [7:0] v, input logic exp_nack, input string req);
        logic n;
        send_byte(v, n);
        chk(n == exp_nack, req, n, exp_nack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
        chk(mem_we == 1'b0 && mem_re == 1'b0, "R1 strobes low", {mem_we, mem_re}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R3 R4: write three bytes into page 2 from 0x10
        bus_start();
        put(8'hA4, 1'b0, "R2 control ack");
        put(8'h10, 1'b0, "R3 word address ack");
        put(8'h5A, 1'b0, "R3 data ack");
        put(8'hC3, 1'b0, "R4 data ack");
        put(8'h7E, 1'b0, "R4 data ack");
        bus_stop();

        // R6 random read via repeated Start
        bus_start();
        put(8'hA4, 1'b0, "R6 control ack");
        put(8'h10, 1'b0, "R6 word ack");
        bus_start();
        put(8'hA5, 1'b0, "R6 read control ack");
        expect_byte(8'h5A);
        expect_byte(8'hC3);
        recv_byte(1'b1);
        recv_byte(1'b0);
        repeat (Q) @(negedge clk);
        chk(sda_pull == 1'b0, "R6 released after NACK", sda_pull, 0);
        bus_stop();

        // R6 read continues from the retained pointer (0x212)
        bus_start();
        put(8'hA5, 1'b0, "R6 current read ack");
        expect_byte(8'h7E);
        recv_byte(1'b0);
        bus_stop();

        // R2 wrong device type is ignored until the next Start
        bus_start();
        put(8'hB4, 1'b1, "R2 foreign type NACK");
        put(8'h00, 1'b1, "R2 ignored after NACK");
        bus_stop();

        // R5 write protect
        wp = 1'b1;
        bus_start();
        put(8'hA4, 1'b0, "R5 control ack under wp");
        put(8'h10, 1'b0, "R5 word ack under wp");
        put(8'hFF, 1'b1, "R5 data NACK under wp");
        bus_stop();
        wp = 1'b0;
        bus_start();
        put(8'hA5, 1'b0, "R5 read ack");
        expect_byte(8'h5A);   // not overwritten, pointer still 0x210
        recv_byte(1'b0);
        bus_stop();

        // R4 wrap from 0x7FF to 0x000
        bus_start();
        put(8'hAE, 1'b0, "R4 control ack page 7");
        put(8'hFF, 1'b0, "R4 word ack");
        put(8'h11, 1'b0, "R4 data at 0x7FF");
        put(8'h22, 1'b0, "R4 data at 0x000");
        bus_stop();
        bus_start();
        put(8'hAE, 1'b0, "R4 control ack");
        put(8'hFF, 1'b0, "R4 word ack");
        bus_start();
        put(8'hAF, 1'b0, "R4 read control ack");
        expect_byte(8'h11);
        expect_byte(8'h22);
        recv_byte(1'b1);
        recv_byte(1'b0);
        bus_stop();

        // R7 abort by Start after four bits
        bus_start();
        put(8'hA4, 1'b0, "R7 control ack");
        put(8'h20, 1'b0, "R7 word ack");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        put(8'hA4, 1'b0, "R7 rearmed after Start");
        put(8'h20, 1'b0, "R7 word ack");
        bus_start();
        put(8'hA5, 1'b0, "R7 read ack");
        expect_byte(8'h00);
        recv_byte(1'b0);
        bus_stop();

        // R7 abort by Stop after four bits
        bus_start();
        put(8'hA4, 1'b0, "R7 control ack");
        put(8'h21, 1'b0, "R7 word ack");
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        bus_start();
        put(8'hA4, 1'b0, "R7 control ack");
        put(8'h21, 1'b0, "R7 word ack");
        bus_start();
        put(8'hA5, 1'b0, "R7 read ack");
        expect_byte(8'h00);
        recv_byte(1'b0);
        bus_stop();

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all expected bytes seen", exp_q.size(), 0);
        chk(r8_viol == 0, "R8 SDA drive changed while SCL high", r8_viol, 0);
        chk(r9_viol == 0, "R9 strobes together", r9_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule